// File: doc/BRIEF.md
# SCCB Single-Byte Register Access Master

This block is a two-wire bus master for camera-style SCCB peripherals. It performs exactly one register access per command: it either writes one data byte into a register of the external device or reads one byte back from it. A host programs a 7-bit device ID, an 8-bit register sub-address, a transmit byte and the direction through a small register interface. It then issues a start command. The block runs the whole bus sequence by itself and drives SCL and SDA as open-drain lines: an asserted output enable pulls the line low, and a released enable lets it float high.

A write is a single bus phase. A read uses two phases: the first phase sets the register pointer, and the second fetches the byte and ends it with a not-acknowledge. The acknowledge bit the device returns after each byte is ignored. A programmable divider sets the bus bit rate. Sticky status flags report completion, received data and consumption of the transmit byte, and the host clears each flag by writing a 1 to it. A debug register shows the live levels of both lines as the block drives them and as it samples them.

Top module: `sccb_xfer_master`

## Requirements
- R1: A write command (CTRL bit0=1, bit1=1) produces exactly one START, the bytes {ID,0}, sub-address and TXDATA, then one STOP. Bytes go MSB first, and each byte is followed by one released acknowledge slot.
- R2: A read command (CTRL bit0=1, bit1=0) produces START, {ID,0}, sub-address, STOP, then START, {ID,1}, one byte clocked in from the device, a master NACK (SDA released, sampled 1), and STOP. The received byte is readable at RXDATA (address 4).
- R3: Writing CTRL (address 0) with bit7=1 starts a command only if bit0 of the same write is 1. Bit1 of that write selects write (1) or read (0). CTRL reads back bit0 and bit1.
- R4: SDA changes only while SCL is low, with two exceptions: START, where SDA falls while SCL is high, and STOP, where SDA rises while SCL is high.
- R5: Within a byte, the SCL period is 4*(DIV+1) system clocks. DIV is the register at address 7.
- R6: STATUS bit7 (busy) is 1 from the accepted start command until STOP completes. A start command written while busy is ignored.
- R7: STATUS (address 5) bit0 = done is set when a command completes. Bit1 = rx-ready is set when a read completes. Bit2 = tx-request is set when the write data byte is taken. These bits stay set until a 1 is written to them at address 5, and clearing CTRL bit0 does not clear them.
- R8: PINS (address 6) reads bit3 = sampled SCL, bit2 = driven SCL level, bit1 = sampled SDA, bit0 = driven SDA level.
- R9: After reset both lines are released, CTRL and STATUS read 0, and DIV reads its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| scl_i | input | 1 | SCL line level |
| scl_oe_o | output | 1 | SCL pull-low enable |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | SDA pull-low enable |

## Verification
The bench builds the block with DIV_RST=1 and then reprograms the divider to 0, 1 and 2. These values keep each command to a few hundred clocks, so several device IDs, sub-addresses and data patterns fit into every divider setting. The setting DIV=0 leaves only a one-clock quarter bit, which is the tightest margin between a device changing SDA after an SCL fall and the two-stage input synchronizer delivering that bit before it is sampled. A device model on the lines decodes START, STOP and the byte stream, and it drives read data during the second phase.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WBYTE, OP_RBYTE} op_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_ID   = 3'd1;
  localparam logic [2:0] A_SUB  = 3'd2;
  localparam logic [2:0] A_TXD  = 3'd3;
  localparam logic [2:0] A_RXD  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [2:0] A_PINS = 3'd6;
  localparam logic [2:0] A_DIV  = 3'd7;

  localparam int unsigned LAST_WR = 4;
  localparam int unsigned LAST_RD = 7;
endpackage

// File: rtl/sccb_tick_gen.sv
module sccb_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q >= div_i)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q >= div_i);

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $stable(div_i)) |-> (cnt_q <= div_i));
endmodule

// File: rtl/sccb_bit_engine.sv
module sccb_bit_engine
  import sccb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       op_valid_i,
  input  op_e        op_i,
  input  logic [7:0] byte_i,
  input  logic       sda_i,
  output logic       active_o,
  output logic       op_done_o,
  output logic [7:0] rx_byte_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       active_q, done_q, scl_oe_q, sda_oe_q;
  op_e        op_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       is_byte, last_q;

  assign is_byte = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);
  assign last_q  = (q_q == 2'd3) && (!is_byte || bit_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      op_q     <= OP_START;
      q_q      <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (op_valid_i) begin
          active_q <= 1'b1;
          op_q     <= op_i;
          q_q      <= '0;
          bit_q    <= '0;
          sh_q     <= byte_i;
        end
      end else if (tick_i) begin
        unique case (op_q)
          OP_START: begin
            case (q_q)
              2'd0:    sda_oe_q <= 1'b0;
              2'd1:    scl_oe_q <= 1'b0;
              2'd2:    sda_oe_q <= 1'b1;
              default: scl_oe_q <= 1'b1;
            endcase
          end
          OP_STOP: begin
            case (q_q)
              2'd0:    sda_oe_q <= 1'b1;
              2'd1:    scl_oe_q <= 1'b0;
              2'd2:    sda_oe_q <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (q_q)
              2'd0:    sda_oe_q <= (op_q == OP_WBYTE) && (bit_q != 4'd8) && !sh_q[7];
              2'd1:    scl_oe_q <= 1'b0;
              2'd2:    if (bit_q != 4'd8) sh_q <= {sh_q[6:0], sda_i};
              default: scl_oe_q <= 1'b1;
            endcase
          end
        endcase
        q_q <= q_q + 1'b1;
        if (q_q == 2'd3) begin
          if (last_q) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  assign active_o  = active_q;
  assign op_done_o = done_q;
  assign rx_byte_o = sh_q;
  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;

  // R4
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_q && !$past(scl_oe_q) && (sda_oe_q != $past(sda_oe_q)))
      |-> (op_q == OP_START || op_q == OP_STOP));
  // R2
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && op_q == OP_RBYTE) |-> !sda_oe_q);
endmodule

// File: rtl/sccb_seq.sv
module sccb_seq
  import sccb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       rd_i,
  input  logic [6:0] id_i,
  input  logic [7:0] sub_i,
  input  logic [7:0] txd_i,
  input  logic       eng_done_i,
  input  logic [7:0] eng_rx_i,
  output logic       op_valid_o,
  output op_e        op_o,
  output logic [7:0] byte_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic       fin_rd_o,
  output logic       tx_take_o,
  output logic [7:0] rxd_o
);
  logic       busy_q, issue_q, rd_q, fin_q, fin_rd_q;
  logic [3:0] step_q, last_step;
  logic [6:0] id_q;
  logic [7:0] sub_q, txd_q, rxd_q;

  assign last_step = rd_q ? 4'(LAST_RD) : 4'(LAST_WR);

  always_comb begin
    op_o   = OP_START;
    byte_o = '0;
    if (!rd_q) begin
      case (step_q)
        4'd0:    op_o = OP_START;
        4'd1:    begin op_o = OP_WBYTE; byte_o = {id_q, 1'b0}; end
        4'd2:    begin op_o = OP_WBYTE; byte_o = sub_q; end
        4'd3:    begin op_o = OP_WBYTE; byte_o = txd_q; end
        default: op_o = OP_STOP;
      endcase
    end else begin
      case (step_q)
        4'd0, 4'd4: op_o = OP_START;
        4'd1:    begin op_o = OP_WBYTE; byte_o = {id_q, 1'b0}; end
        4'd2:    begin op_o = OP_WBYTE; byte_o = sub_q; end
        4'd5:    begin op_o = OP_WBYTE; byte_o = {id_q, 1'b1}; end
        4'd6:    op_o = OP_RBYTE;
        default: op_o = OP_STOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      issue_q  <= 1'b0;
      rd_q     <= 1'b0;
      fin_q    <= 1'b0;
      fin_rd_q <= 1'b0;
      step_q   <= '0;
      id_q     <= '0;
      sub_q    <= '0;
      txd_q    <= '0;
      rxd_q    <= '0;
    end else begin
      fin_q    <= 1'b0;
      fin_rd_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q  <= 1'b1;
        issue_q <= 1'b1;
        step_q  <= '0;
        rd_q    <= rd_i;
        id_q    <= id_i;
        sub_q   <= sub_i;
        txd_q   <= txd_i;
      end else begin
        if (issue_q) issue_q <= 1'b0;
        if (eng_done_i && busy_q) begin
          if (rd_q && step_q == 4'd6) rxd_q <= eng_rx_i;
          if (step_q == last_step) begin
            busy_q   <= 1'b0;
            fin_q    <= 1'b1;
            fin_rd_q <= rd_q;
          end else begin
            step_q  <= step_q + 1'b1;
            issue_q <= 1'b1;
          end
        end
      end
    end
  end

  assign op_valid_o = issue_q;
  assign busy_o     = busy_q;
  assign fin_o      = fin_q;
  assign fin_rd_o   = fin_rd_q;
  assign tx_take_o  = issue_q && !rd_q && (step_q == 4'd3);
  assign rxd_o      = rxd_q;

  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(eng_done_i));
  // R1
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (step_q <= last_step));
endmodule

// File: rtl/sccb_regs.sv
module sccb_regs
  import sccb_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             busy_i,
  input  logic             fin_i,
  input  logic             fin_rd_i,
  input  logic             tx_take_i,
  input  logic [7:0]       rxd_i,
  input  logic [3:0]       pins_i,
  output logic             go_o,
  output logic             rd_o,
  output logic [6:0]       id_o,
  output logic [7:0]       sub_o,
  output logic [7:0]       txd_o,
  output logic [DIV_W-1:0] div_o
);
  logic             mst_q, tx_q, done_q, rxr_q, txr_q;
  logic [6:0]       id_q;
  logic [7:0]       sub_q, txd_q, rxd_q;
  logic [DIV_W-1:0] div_q;
  logic             wr_ctrl, wr_stat;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_stat = wr_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q  <= 1'b0;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
      rxr_q  <= 1'b0;
      txr_q  <= 1'b0;
      id_q   <= '0;
      sub_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      div_q  <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        mst_q <= wdata_i[0];
        tx_q  <= wdata_i[1];
      end
      if (wr_i && addr_i == A_ID)  id_q  <= wdata_i[6:0];
      if (wr_i && addr_i == A_SUB) sub_q <= wdata_i;
      if (wr_i && addr_i == A_TXD) txd_q <= wdata_i;
      if (wr_i && addr_i == A_DIV) div_q <= wdata_i[DIV_W-1:0];
      if (fin_rd_i) rxd_q <= rxd_i;
      // set wins over a simultaneous clear
      done_q <= fin_i     || (done_q && !(wr_stat && wdata_i[0]));
      rxr_q  <= fin_rd_i  || (rxr_q  && !(wr_stat && wdata_i[1]));
      txr_q  <= tx_take_i || (txr_q  && !(wr_stat && wdata_i[2]));
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {6'b0, tx_q, mst_q};
      A_ID:    rdata_o = {1'b0, id_q};
      A_SUB:   rdata_o = sub_q;
      A_TXD:   rdata_o = txd_q;
      A_RXD:   rdata_o = rxd_q;
      A_STAT:  rdata_o = {busy_i, 4'b0, txr_q, rxr_q, done_q};
      A_PINS:  rdata_o = {4'b0, pins_i};
      default: rdata_o = 8'(div_q);
    endcase
  end

  assign go_o  = wr_ctrl && wdata_i[7] && wdata_i[0];
  assign rd_o  = !wdata_i[1];
  assign id_o  = id_q;
  assign sub_o = sub_q;
  assign txd_o = txd_q;
  assign div_o = div_q;

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(wr_stat && wdata_i[0])) |=> done_q);
  // R7
  rxr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxr_q && !(wr_stat && wdata_i[1])) |=> rxr_q);
endmodule

// File: rtl/sccb_xfer_master.sv
module sccb_xfer_master
  import sccb_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       scl_i,
  output logic       scl_oe_o,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic [1:0]       scl_s, sda_s;
  logic             go, rd, busy, fin, fin_rd, tx_take, tick;
  logic             op_valid, eng_active, eng_done, scl_oe, sda_oe;
  logic [6:0]       id;
  logic [7:0]       sub, txd, rxd, op_byte, eng_rx;
  logic [DIV_W-1:0] div;
  op_e              op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
    end
  end

  sccb_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) regs_i (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .fin_i(fin), .fin_rd_i(fin_rd), .tx_take_i(tx_take), .rxd_i(rxd),
    .pins_i({scl_s[1], !scl_oe, sda_s[1], !sda_oe}),
    .go_o(go), .rd_o(rd), .id_o(id), .sub_o(sub), .txd_o(txd), .div_o(div)
  );

  sccb_seq seq_i (
    .clk_i, .rst_ni,
    .go_i(go), .rd_i(rd), .id_i(id), .sub_i(sub), .txd_i(txd),
    .eng_done_i(eng_done), .eng_rx_i(eng_rx),
    .op_valid_o(op_valid), .op_o(op), .byte_o(op_byte),
    .busy_o(busy), .fin_o(fin), .fin_rd_o(fin_rd), .tx_take_o(tx_take), .rxd_o(rxd)
  );

  sccb_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk_i, .rst_ni, .run_i(eng_active), .div_i(div), .tick_o(tick)
  );

  sccb_bit_engine eng_i (
    .clk_i, .rst_ni, .tick_i(tick),
    .op_valid_i(op_valid), .op_i(op), .byte_i(op_byte), .sda_i(sda_s[1]),
    .active_o(eng_active), .op_done_o(eng_done), .rx_byte_o(eng_rx),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  assign scl_oe_o = scl_oe;
  assign sda_oe_o = sda_oe;

  // R9
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/sccb_xfer_master_tb.sv
module sccb_xfer_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_RST    = 1;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       scl_oe, sda_oe, slv_pull = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_pull);

  sccb_xfer_master #(.DIV_W(8), .DIV_RST(DIV_RST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .scl_i(scl_line), .scl_oe_o(scl_oe), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  int nchk = 0, nbad = 0;
  int cyc = 0;

  // device model / monitor
  int   nstart = 0, nstop = 0, nbytes = 0, bitn = 0;
  logic rd_frame = 1'b0;
  logic [7:0] cur = '0, rdval = '0;
  logic [7:0] blog [0:511];
  logic       alog [0:511];
  longint t_last = 0, per = 0;

  always @(negedge sda_line) if (scl_line) begin
    nstart++; bitn = 0; rd_frame = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) nstop++;
  always @(posedge scl_line) begin
    if (bitn == 1) per = $time - t_last;
    t_last = $time;
    cur = {cur[6:0], sda_line};
    bitn++;
    if (bitn == 8 && sda_line) rd_frame = 1'b1;
    if (bitn % 9 == 8) begin blog[nbytes] = cur; end
    if (bitn % 9 == 0) begin alog[nbytes] = sda_line; nbytes++; end
  end
  always @(negedge scl_line) begin
    if (rd_frame && bitn >= 9 && bitn <= 16) slv_pull = !rdval[16-bitn];
    else slv_pull = 1'b0;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  logic saw_slave_low = 1'b0, saw_scl_low = 1'b0, pins_bad = 1'b0;

  task automatic wait_idle();
    logic [7:0] s, p;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(3'd6, p);
      if (p[1] == 1'b0 && p[0] == 1'b1) saw_slave_low = 1'b1;
      if (p[2] == 1'b0) saw_scl_low = 1'b1;
      if (p[2] != !scl_oe || p[0] != !sda_oe) pins_bad = 1'b1;
      reg_rd(3'd5, s);
      if (!s[7]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] id, input logic [7:0] sub, input logic [7:0] d, input int div);
    int b0, s0, p0;
    logic [7:0] st;
    reg_wr(3'd5, 8'h07);
    reg_wr(3'd1, {1'b0, id}); reg_wr(3'd2, sub); reg_wr(3'd3, d);
    b0 = nbytes; s0 = nstart; p0 = nstop;
    reg_wr(3'd0, 8'h83);
    reg_rd(3'd5, st);
    chk(st[7] == 1'b1, "R6 busy after go", st, 8'h80);
    wait_idle();
    chk(nbytes - b0 == 3, "R1 byte count", nbytes - b0, 3);
    chk(blog[b0] == {id, 1'b0}, "R1 id byte", blog[b0], {id, 1'b0});
    chk(blog[b0+1] == sub, "R1 sub byte", blog[b0+1], sub);
    chk(blog[b0+2] == d, "R1 data byte", blog[b0+2], d);
    chk(nstart - s0 == 1 && nstop - p0 == 1, "R4 one START/STOP", (nstart-s0)*16+(nstop-p0), 8'h11);
    chk(per == longint'(4*(div+1)*CLK_PERIOD), "R5 scl period", int'(per), 4*(div+1)*CLK_PERIOD);
    reg_rd(3'd5, st);
    chk(st == 8'h05, "R7 status after write", st, 8'h05);
  endtask

  task automatic do_read(input logic [6:0] id, input logic [7:0] sub, input logic [7:0] v, input int div);
    int b0, s0, p0;
    logic [7:0] st, rx;
    rdval = v;
    reg_wr(3'd5, 8'h07);
    reg_wr(3'd1, {1'b0, id}); reg_wr(3'd2, sub);
    b0 = nbytes; s0 = nstart; p0 = nstop;
    reg_wr(3'd0, 8'h81);
    wait_idle();
    chk(nbytes - b0 == 4, "R2 byte count", nbytes - b0, 4);
    chk(blog[b0] == {id, 1'b0}, "R2 id write byte", blog[b0], {id, 1'b0});
    chk(blog[b0+1] == sub, "R2 sub byte", blog[b0+1], sub);
    chk(blog[b0+2] == {id, 1'b1}, "R2 id read byte", blog[b0+2], {id, 1'b1});
    chk(blog[b0+3] == v, "R2 line data", blog[b0+3], v);
    chk(alog[b0+3] == 1'b1, "R2 master NACK", alog[b0+3], 1);
    chk(nstart - s0 == 2 && nstop - p0 == 2, "R4 two START/STOP", (nstart-s0)*16+(nstop-p0), 8'h22);
    chk(per == longint'(4*(div+1)*CLK_PERIOD), "R5 scl period", int'(per), 4*(div+1)*CLK_PERIOD);
    reg_rd(3'd4, rx);
    chk(rx == v, "R2 rxdata", rx, v);
    reg_rd(3'd5, st);
    chk(st == 8'h03, "R7 status after read", st, 8'h03);
  endtask

  initial begin
    logic [7:0] r;
    int s0, b0;
    repeat (3) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 lines released in reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    reg_rd(3'd0, r); chk(r == 8'h00, "R9 ctrl reset", r, 0);
    reg_rd(3'd5, r); chk(r == 8'h00, "R9 status reset", r, 0);
    reg_rd(3'd7, r); chk(r == 8'(DIV_RST), "R9 div reset", r, DIV_RST);
    reg_rd(3'd6, r); chk(r == 8'h0F, "R8 pins idle", r, 8'h0F);

    for (int d = 0; d < 3; d++) begin
      reg_wr(3'd7, 8'(d));
      reg_rd(3'd7, r); chk(r == 8'(d), "R5 div readback", r, d);
      for (int k = 0; k < 4; k++)
        do_write(7'((k*37 + d*11 + 5) & 8'h7f), 8'((k*53 + d*7 + 1) & 8'hff),
                 8'((k*91 + d*29 + 8'hA5) & 8'hff), d);
      for (int k = 0; k < 4; k++)
        do_read(7'((k*45 + d*13 + 3) & 8'h7f), 8'((k*71 + d*3 + 2) & 8'hff),
                8'((k*149 + d*17 + 8'h3C) & 8'hff), d);
    end
    do_write(7'h7f, 8'hff, 8'h00, 2);
    do_read(7'h00, 8'h00, 8'hff, 2);
    do_read(7'h7f, 8'hff, 8'h00, 2);

    // R3 go without master bit is ignored; direction bit reads back
    reg_wr(3'd5, 8'h07);
    s0 = nstart;
    reg_wr(3'd0, 8'h82);
    reg_rd(3'd5, r); chk(r[7] == 1'b0, "R3 no start without master", r, 0);
    repeat (60) @(negedge clk);
    chk(nstart == s0, "R3 no bus activity", nstart - s0, 0);
    reg_rd(3'd0, r); chk(r == 8'h02, "R3 ctrl readback", r, 8'h02);

    // R6 go while busy ignored
    reg_wr(3'd1, 8'h21); reg_wr(3'd2, 8'h44); reg_wr(3'd3, 8'h99);
    s0 = nstart; b0 = nbytes;
    reg_wr(3'd0, 8'h83);
    repeat (40) @(negedge clk);
    reg_wr(3'd0, 8'h81);
    wait_idle();
    chk(nstart - s0 == 1, "R6 second go ignored", nstart - s0, 1);
    chk(nbytes - b0 == 3 && blog[b0+2] == 8'h99, "R6 write completed", nbytes - b0, 3);

    // R7 sticky: clearing master does not clear, w1c per bit
    reg_wr(3'd0, 8'h00);
    reg_rd(3'd5, r); chk(r == 8'h05, "R7 kept after ctrl clear", r, 8'h05);
    reg_wr(3'd5, 8'h01);
    reg_rd(3'd5, r); chk(r == 8'h04, "R7 w1c done only", r, 8'h04);
    reg_wr(3'd5, 8'h02);
    reg_rd(3'd5, r); chk(r == 8'h04, "R7 w1c unset bit no effect", r, 8'h04);
    reg_wr(3'd5, 8'h04);
    reg_rd(3'd5, r); chk(r == 8'h00, "R7 w1c txreq", r, 0);

    // R8 live pins
    chk(saw_slave_low, "R8 sda in low while out high", saw_slave_low, 1);
    chk(saw_scl_low, "R8 scl out low seen", saw_scl_low, 1);
    chk(!pins_bad, "R8 driven levels match lines", pins_bad, 0);
    reg_rd(3'd6, r); chk(r == 8'h0F, "R8 pins idle after run", r, 8'h0F);

    summary();
    $finish;
  end
endmodule